// File: doc/BRIEF.md
# Write-Coalescing Request Buffer Controller

This controller sits between a processor memory port and a resistive non-volatile memory. Processor writes are not sent to the memory right away. Each write is placed in a small ordered wait buffer, and reads are first checked against that buffer. Once enough writes have gathered, the oldest of them are frozen as a locked batch. The batch is streamed, one word per handshake, to a downstream batch writer that programs the array. The writer reports with a single pulse when the whole batch has been programmed. Until that pulse arrives the memory counts as busy. After it, the streamed entries leave the buffer.

The wait buffer always holds the newest copy of each address it contains. A read that matches an entry is answered from the buffer, and the newest matching copy wins. A read that matches no entry goes to the memory. If the memory is busy with a batch, that read is parked in a one-entry read buffer and the processor is stalled until the batch completes. A write to an address that still sits in the unlocked part of the buffer overwrites that entry. A write to an address that is only held in the locked batch opens a new entry. A flush pulse at the end of a computation phase forces the remaining entries out as a short batch.

Top module: `wcb_ctrl`

## Requirements
- R1: Accepted writes raise no memory read and no batch word while fewer than BATCH unlocked entries are held and no flush is pending.
- R2: When BATCH unlocked entries are held and no batch is locked, the BATCH oldest entries are locked. They are then streamed oldest first, one word per cycle in which `wb_ready` is high. `wb_last` is high only on the final word.
- R3: A read that matches a buffered entry, locked or not, gives `rsp_valid` in the next cycle with the buffered data. It raises no memory read.
- R4: A read that matches no entry while the memory is idle raises `mem_rd_en` in the same cycle with the read address. The next cycle gives `rsp_valid`, and `rsp_rdata` equals `mem_rd_data`.
- R5: A write to an address held only in the locked batch opens a new entry. Later reads of that address return the new data, and the locked batch still streams the old data.
- R6: A read that matches no entry while a batch is in flight is parked, and `req_ready` is low until it is served. `mem_rd_en` stays low until `wb_done` ends the batch. In the cycle after that, `mem_rd_en` rises with the parked address, and the response follows one cycle later.
- R7: A `flush` pulse locks and streams all pending unlocked entries, even when there are fewer than BATCH of them.
- R8: A write to an address that is held in an unlocked entry overwrites that entry's data. It takes no new slot, so it does not count toward BATCH.
- R9: When DEPTH entries are held, `req_ready` is low for a write request and stays high for a read request.
- R10: After `wb_done`, the streamed entries leave the buffer, and a later read of one of their addresses goes to memory.
- R11: During and right after reset, `req_ready` is high and `rsp_valid`, `wb_valid` and `mem_rd_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Processor request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Write data |
| req_ready | output | 1 | Request accepted this cycle |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | DW | Read data |
| flush | input | 1 | End-of-phase pulse: drain pending writes |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | AW | Memory read address |
| mem_rd_data | input | DW | Memory read data, valid one cycle after the strobe |
| wb_valid | output | 1 | Batch word offered to writer |
| wb_addr | output | AW | Batch word address |
| wb_data | output | DW | Batch word data |
| wb_last | output | 1 | Final word of the batch |
| wb_ready | input | 1 | Writer takes the offered word |
| wb_done | input | 1 | Writer finished programming the batch |

## Verification
A wrong head, tail or count would show up on the writer port. Batches would start at the wrong write count or stream the wrong words, and this is visible within a few cycles of the BATCH-th write. A lost lock or park flag would show up on the memory read port. A read would go to memory during a batch, or a stall would never lift. A stale or wrong-priority match would return old data one cycle after the read is accepted. The directed scenarios place a read right after each such event, so a corrupted entry surfaces at the next response.

// File: rtl/wcb_pkg.sv
package wcb_pkg;
  typedef enum logic [1:0] {
    RSP_NONE = 2'd0,
    RSP_BUF  = 2'd1,
    RSP_MEM  = 2'd2
  } rsp_src_e;
endpackage

// File: rtl/wcb_store.sv
module wcb_store #(
  parameter int DEPTH = 80,
  parameter int AW    = 8,
  parameter int DW    = 8,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  input  logic [CW-1:0] lock_cnt,
  input  logic          release_en,
  input  logic [CW-1:0] send_off,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          rd_hit,
  output logic [DW-1:0] rd_data,
  output logic [AW-1:0] send_addr,
  output logic [DW-1:0] send_data
);
  logic [PW-1:0] head_q, head_d, tail_q, tail_d;
  logic [CW-1:0] count_q, count_d;
  logic [DEPTH-1:0][AW-1:0] addr_v;
  logic [DEPTH-1:0][DW-1:0] data_v;
  logic [DEPTH-1:0] live, held, wr_upd_hit, rd_new_hit, rd_old_hit;
  logic append;

  assign append = wr_en && !(|wr_upd_hit);

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic [AW-1:0] ent_a_q;
    logic [DW-1:0] ent_d_q;
    int age;
    always_comb begin
      if (g >= int'(head_q)) age = g - int'(head_q);
      else                   age = g + DEPTH - int'(head_q);
    end
    assign live[g]       = age < int'(count_q);
    assign held[g]       = age < int'(lock_cnt);
    assign wr_upd_hit[g] = live[g] && !held[g] && (ent_a_q == wr_addr);
    assign rd_new_hit[g] = live[g] && !held[g] && (ent_a_q == rd_addr);
    assign rd_old_hit[g] = held[g] && (ent_a_q == rd_addr);
    always_ff @(posedge clk) begin
      if (wr_en && (wr_upd_hit[g] || (append && tail_q == PW'(g)))) begin
        ent_a_q <= wr_addr;
        ent_d_q <= wr_data;
      end
    end
    assign addr_v[g] = ent_a_q;
    assign data_v[g] = ent_d_q;
  end

  // newest copy wins: an unlocked match is always younger than a locked one
  always_comb begin
    rd_hit  = 1'b0;
    rd_data = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (rd_old_hit[i]) begin rd_hit = 1'b1; rd_data = data_v[i]; end
    end
    for (int i = 0; i < DEPTH; i++) begin
      if (rd_new_hit[i]) begin rd_hit = 1'b1; rd_data = data_v[i]; end
    end
  end

  always_comb begin
    int s;
    s = int'(head_q) + int'(send_off);
    if (s >= DEPTH) s = s - DEPTH;
    send_addr = addr_v[PW'(s)];
    send_data = data_v[PW'(s)];
  end

  always_comb begin
    int h;
    head_d  = head_q;
    tail_d  = tail_q;
    count_d = count_q + CW'(append);
    if (append) tail_d = (tail_q == PW'(DEPTH - 1)) ? '0 : tail_q + PW'(1);
    h = int'(head_q) + int'(lock_cnt);
    if (h >= DEPTH) h = h - DEPTH;
    if (release_en) begin
      head_d  = PW'(h);
      count_d = count_q + CW'(append) - lock_cnt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else begin
      head_q  <= head_d;
      tail_q  <= tail_d;
      count_q <= count_d;
    end
  end

  assign count = count_q;
  assign full  = (count_q == CW'(DEPTH));

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count_q) <= DEPTH);
  assert_full_no_append_R9: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !append);
  assert_unlocked_unique_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rd_new_hit));
endmodule

// File: rtl/wcb_batch.sv
module wcb_batch #(
  parameter int DEPTH = 80,
  parameter int BATCH = 10,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] count,
  input  logic          flush,
  input  logic          wb_ready,
  input  logic          wb_done,
  output logic [CW-1:0] lock_cnt,
  output logic [CW-1:0] send_off,
  output logic          wb_valid,
  output logic          wb_last,
  output logic          busy,
  output logic          release_en
);
  logic          locked_q, locked_d, fpend_q, fpend_d;
  logic [CW-1:0] lock_q, lock_d, sent_q, sent_d, ucnt;
  logic          want_flush, sending;

  assign ucnt       = count - lock_q;
  assign want_flush = fpend_q || flush;
  assign sending    = locked_q && (sent_q < lock_q);
  assign release_en = locked_q && !sending && wb_done;

  always_comb begin
    locked_d = locked_q;
    lock_d   = lock_q;
    sent_d   = sent_q;
    fpend_d  = want_flush;
    if (!locked_q) begin
      if (ucnt >= CW'(BATCH)) begin
        locked_d = 1'b1;
        lock_d   = CW'(BATCH);
        sent_d   = '0;
        if (ucnt == CW'(BATCH)) fpend_d = 1'b0;
      end else if (want_flush) begin
        fpend_d = 1'b0;
        if (ucnt != '0) begin
          locked_d = 1'b1;
          lock_d   = ucnt;
          sent_d   = '0;
        end
      end
    end else begin
      if (sending && wb_ready) sent_d = sent_q + CW'(1);
      if (release_en) begin
        locked_d = 1'b0;
        lock_d   = '0;
        sent_d   = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked_q <= 1'b0;
      lock_q   <= '0;
      sent_q   <= '0;
      fpend_q  <= 1'b0;
    end else begin
      locked_q <= locked_d;
      lock_q   <= lock_d;
      sent_q   <= sent_d;
      fpend_q  <= fpend_d;
    end
  end

  assign lock_cnt = lock_q;
  assign send_off = sent_q;
  assign wb_valid = sending;
  assign wb_last  = sending && (sent_q == lock_q - CW'(1));
  assign busy     = locked_q;

  assert_batch_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(lock_q) <= BATCH);
  assert_stream_starts_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> wb_valid && (send_off == '0));
  assert_lock_nonempty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> lock_cnt != '0);
  assert_release_frees_R10: assert property (@(posedge clk) disable iff (!rst_n)
    release_en |=> !busy);
endmodule

// File: rtl/wcb_rdpath.sv
module wcb_rdpath
  import wcb_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_req,
  input  logic [AW-1:0] rd_addr,
  input  logic          hit,
  input  logic [DW-1:0] hit_data,
  input  logic          busy,
  input  logic [DW-1:0] mem_rd_data,
  output logic          mem_rd_en,
  output logic [AW-1:0] mem_rd_addr,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          stall
);
  logic          park_q, park_d;
  logic [AW-1:0] park_a_q, park_a_d;
  logic [DW-1:0] buf_q, buf_d;
  rsp_src_e      src_q, src_d;

  always_comb begin
    park_d      = park_q;
    park_a_d    = park_a_q;
    buf_d       = buf_q;
    src_d       = RSP_NONE;
    mem_rd_en   = 1'b0;
    mem_rd_addr = rd_addr;
    if (park_q && !busy) begin
      mem_rd_en   = 1'b1;
      mem_rd_addr = park_a_q;
      park_d      = 1'b0;
      src_d       = RSP_MEM;
    end else if (rd_req) begin
      if (hit) begin
        buf_d = hit_data;
        src_d = RSP_BUF;
      end else if (!busy) begin
        mem_rd_en = 1'b1;
        src_d     = RSP_MEM;
      end else begin
        park_d   = 1'b1;
        park_a_d = rd_addr;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      park_q   <= 1'b0;
      park_a_q <= '0;
      buf_q    <= '0;
      src_q    <= RSP_NONE;
    end else begin
      park_q   <= park_d;
      park_a_q <= park_a_d;
      buf_q    <= buf_d;
      src_q    <= src_d;
    end
  end

  assign rsp_valid = (src_q != RSP_NONE);
  assign rsp_rdata = (src_q == RSP_MEM) ? mem_rd_data : buf_q;
  assign stall     = park_q;

  assert_hit_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && hit |=> rsp_valid);
  assert_miss_idle_direct_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !hit && !busy |-> mem_rd_en && (mem_rd_addr == rd_addr));
  assert_park_on_busy_miss_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !hit && busy |=> stall && !rsp_valid);
  assert_no_mem_read_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> !busy);
endmodule

// File: rtl/wcb_ctrl.sv
module wcb_ctrl #(
  parameter int DEPTH = 80,
  parameter int BATCH = 10,
  parameter int AW    = 8,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ready,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  input  logic          flush,
  output logic          mem_rd_en,
  output logic [AW-1:0] mem_rd_addr,
  input  logic [DW-1:0] mem_rd_data,
  output logic          wb_valid,
  output logic [AW-1:0] wb_addr,
  output logic [DW-1:0] wb_data,
  output logic          wb_last,
  input  logic          wb_ready,
  input  logic          wb_done
);
  localparam int CW = $clog2(DEPTH + 1);

  logic          full, stall, busy, release_en, rd_hit, wr_en, rd_req;
  logic [CW-1:0] count, lock_cnt, send_off;
  logic [DW-1:0] rd_data;

  assign req_ready = !stall && !(req_write && full);
  assign wr_en     = req_valid && req_ready && req_write;
  assign rd_req    = req_valid && req_ready && !req_write;

  wcb_store #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(req_addr), .wr_data(req_wdata),
    .rd_addr(req_addr), .lock_cnt(lock_cnt), .release_en(release_en),
    .send_off(send_off), .count(count), .full(full),
    .rd_hit(rd_hit), .rd_data(rd_data),
    .send_addr(wb_addr), .send_data(wb_data)
  );

  wcb_batch #(.DEPTH(DEPTH), .BATCH(BATCH)) u_batch (
    .clk(clk), .rst_n(rst_n), .count(count), .flush(flush),
    .wb_ready(wb_ready), .wb_done(wb_done),
    .lock_cnt(lock_cnt), .send_off(send_off),
    .wb_valid(wb_valid), .wb_last(wb_last),
    .busy(busy), .release_en(release_en)
  );

  wcb_rdpath #(.AW(AW), .DW(DW)) u_rdpath (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(req_addr),
    .hit(rd_hit), .hit_data(rd_data), .busy(busy),
    .mem_rd_data(mem_rd_data), .mem_rd_en(mem_rd_en),
    .mem_rd_addr(mem_rd_addr), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .stall(stall)
  );

  assert_full_blocks_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    full && req_write |-> !req_ready);
  assert_stall_blocks_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !req_ready);
endmodule

// File: tb/wcb_ctrl_tb.sv
module wcb_ctrl_tb;
  localparam int DEPTH = 8;
  localparam int BATCH = 3;
  localparam int AW = 8;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_write, req_ready, rsp_valid, flush;
  logic [AW-1:0] req_addr, mem_rd_addr, wb_addr;
  logic [DW-1:0] req_wdata, rsp_rdata, mem_rd_data, wb_data;
  logic mem_rd_en, wb_valid, wb_last, wb_ready, wb_done;

  int total = 0;
  int bad = 0;
  logic [AW-1:0] cap_a [32];
  logic [DW-1:0] cap_d [32];
  logic          cap_l [32];
  int cap_n = 0;

  always #10 clk = ~clk;

  wcb_ctrl #(.DEPTH(DEPTH), .BATCH(BATCH), .AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .flush(flush),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_data(wb_data), .wb_last(wb_last),
    .wb_ready(wb_ready), .wb_done(wb_done)
  );

  // memory model: data is a fixed function of the address, one cycle after the strobe
  always @(posedge clk) if (mem_rd_en) mem_rd_data <= mem_rd_addr ^ 8'hA5;

  always @(posedge clk) begin
    if (rst_n && wb_valid && wb_ready && cap_n < 32) begin
      cap_a[cap_n] <= wb_addr;
      cap_d[cap_n] <= wb_data;
      cap_l[cap_n] <= wb_last;
      cap_n <= cap_n + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(posedge clk); #1;
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd_buf(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string req);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    #1 check(!mem_rd_en, req, mem_rd_en, 0);
    @(posedge clk); #1;
    req_valid = 1'b0;
    @(negedge clk);
    check(rsp_valid && rsp_rdata == exp, req, rsp_rdata, exp);
  endtask

  task automatic rd_mem(input logic [AW-1:0] a, input string req);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    #1 check(mem_rd_en && mem_rd_addr == a, req, mem_rd_addr, a);
    @(posedge clk); #1;
    req_valid = 1'b0;
    @(negedge clk);
    check(rsp_valid && rsp_rdata == (a ^ 8'hA5), req, rsp_rdata, a ^ 8'hA5);
  endtask

  task automatic pulse_done();
    @(negedge clk); wb_done = 1'b1;
    @(negedge clk); wb_done = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(req_ready && !rsp_valid && !wb_valid && !mem_rd_en, "R11", {req_ready, rsp_valid, wb_valid, mem_rd_en}, 4'b1000);
  endtask

  task automatic t_buffer_and_update();
    wr(8'h10, 8'h11);
    wr(8'h10, 8'h12);   // in place: R8
    wr(8'h20, 8'h21);
    idle(3);
    check(cap_n == 0 && !wb_valid, "R1", cap_n, 0);
    check(cap_n == 0, "R8 no batch on overwrite", cap_n, 0);
    rd_buf(8'h10, 8'h12, "R8");
    rd_buf(8'h20, 8'h21, "R3");
  endtask

  task automatic t_miss_idle();
    rd_mem(8'h50, "R4");
  endtask

  task automatic t_batch();
    wr(8'h30, 8'h31);
    idle(6);
    check(cap_n == 3, "R2 count", cap_n, 3);
    check(cap_a[0] == 8'h10 && cap_d[0] == 8'h12 && !cap_l[0], "R2 word0", {cap_a[0], cap_d[0]}, 16'h1012);
    check(cap_a[1] == 8'h20 && cap_d[1] == 8'h21 && !cap_l[1], "R2 word1", {cap_a[1], cap_d[1]}, 16'h2021);
    check(cap_a[2] == 8'h30 && cap_d[2] == 8'h31 && cap_l[2], "R2 word2", {cap_a[2], cap_d[2]}, 16'h3031);
  endtask

  task automatic t_locked_write();
    wr(8'h10, 8'h99);
    rd_buf(8'h10, 8'h99, "R5");
    rd_buf(8'h20, 8'h21, "R3 locked hit");
    check(cap_n == 3 && cap_d[0] == 8'h12, "R5 batch keeps old data", cap_d[0], 8'h12);
  endtask

  task automatic t_park();
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 8'h60;
    #1 check(!mem_rd_en, "R6 no read while busy", mem_rd_en, 0);
    @(posedge clk); #1;
    req_valid = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(!req_ready && !mem_rd_en && !rsp_valid, "R6 stalled", {req_ready, mem_rd_en, rsp_valid}, 0);
    end
    @(negedge clk); wb_done = 1'b1;
    @(negedge clk); wb_done = 1'b0;
    #1 check(mem_rd_en && mem_rd_addr == 8'h60, "R6 replay", mem_rd_addr, 8'h60);
    @(negedge clk);
    check(rsp_valid && rsp_rdata == (8'h60 ^ 8'hA5), "R6 data", rsp_rdata, 8'h60 ^ 8'hA5);
    check(req_ready, "R6 stall lifted", req_ready, 1);
  endtask

  task automatic t_released();
    rd_mem(8'h30, "R10");
    rd_buf(8'h10, 8'h99, "R10 survivor");
  endtask

  task automatic t_flush();
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    idle(4);
    check(cap_n == 4 && cap_a[3] == 8'h10 && cap_d[3] == 8'h99 && cap_l[3], "R7", {cap_a[3], cap_d[3]}, 16'h1099);
    pulse_done();
    rd_mem(8'h10, "R7 drained");
  endtask

  task automatic t_full();
    for (int i = 0; i < DEPTH; i++) wr(8'(8'h80 + i), 8'(i));
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 8'hC0; req_wdata = 8'h00;
    #1 check(!req_ready, "R9 write blocked", req_ready, 0);
    req_write = 1'b0; req_addr = 8'h81;
    #1 check(req_ready, "R9 read allowed", req_ready, 1);
    req_valid = 1'b0;
    rd_buf(8'h87, 8'h07, "R9 read while full");
  endtask

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    flush = 1'b0; wb_ready = 1'b1; wb_done = 1'b0; mem_rd_data = '0;
    idle(3);
    check(req_ready && !rsp_valid && !wb_valid && !mem_rd_en, "R11 in reset", rsp_valid, 0);
    rst_n = 1'b1;
    t_reset();
    t_buffer_and_update();
    t_miss_idle();
    t_batch();
    t_locked_write();
    t_park();
    t_released();
    t_flush();
    t_full();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule